// File: doc/BRIEF.md
# Manchester II Word Transmitter

This block turns a serial stream of sixteen data bits into one framed word on a differential pair of active-low line-driver outputs. Each word starts with a sync character three bit times long whose polarity tells a command word from a data word. The sixteen data bits follow, each Manchester II coded, and a final bit gives the word odd parity. The block runs on a send clock at twice the bit rate. It divides that clock by two to make its own bit-rate shift clock, and brings that clock out so that the external data source can step its bits.

A word begins at a rising shift-clock edge while the enable input is high. The sync type is taken at that same edge. A data-request output then opens a window of sixteen bit times. The source presents one bit per bit time, most significant first, and the block takes each bit at the rising shift-clock edge that closes its bit time. It sends that bit in the next bit time. If enable is still high at the end of a word, the next word follows with no gap. An output inhibit forces the line to idle without disturbing the sequencing. A master reset abandons the word at the next send-clock edge.

Top module: `manch_word_tx`

## Requirements
- R1: While `rst_n` is low, and just after it is released, `one_n` and `zero_n` are both 1, `req` is 0 and `shclk` is 1.
- R2: `shclk` toggles on every send-clock edge, so one bit time is two send-clock cycles. `shclk` is high in the first half of each bit time, and its rising edge marks the bit boundary. A word starts at a bit boundary where `en` is 1 and lasts exactly 20 bit times: bit times 0 to 2 carry the sync, 3 to 18 carry the data and 19 carries the parity.
- R3: `sync_sel` is sampled at the starting boundary. When it is 1 (command), the six sync half-bits are three positive and then three negative. When it is 0 (data), they are three negative and then three positive.
- R4: `req` is 1 in bit times 2 to 17 of a word, 16 bit times in all, and 0 at every other time. `sdi` is sampled at the boundary that ends each of those bit times, and the first bit taken is the MSB.
- R5: The bit taken at the end of bit time k is sent in bit time k+1. A 1 is sent as a positive half followed by a negative half. A 0 is sent as a negative half followed by a positive half.
- R6: Bit time 19 carries a parity bit that gives the 16 data bits plus parity an odd number of ones. It is coded as in R5.
- R7: If `en` is 1 at the boundary that ends bit time 19, the next word starts at once, taking a new sync type. Otherwise the line goes idle.
- R8: While `inh_n` is 0, both line outputs are 1. Sequencing, `req` and data capture carry on unchanged.
- R9: A send-clock edge with `mrst` at 1 ends any word and puts the line at idle. It also puts the half-bit phase back to the first half, so that `shclk` is 1 after that edge.
- R10: The positive state drives `one_n`=0 and `zero_n`=1. The negative state drives `zero_n`=0 and `one_n`=1. Between words both are 1, and the two are never both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Send clock, twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| mrst | input | 1 | Synchronous abort of the current word |
| en | input | 1 | Start or continue words |
| sync_sel | input | 1 | 1 = command sync, 0 = data sync |
| sdi | input | 1 | Serial data from the source, MSB first |
| inh_n | input | 1 | Low forces both line outputs high |
| shclk | output | 1 | Bit-rate shift clock |
| req | output | 1 | Data-request window to the source |
| one_n | output | 1 | Active-low positive-sense line drive |
| zero_n | output | 1 | Active-low negative-sense line drive |

## Verification
Some properties are checked by assertions on every cycle:
- the shift-clock phase alternates;
- a master reset leaves the block idle;
- a word cannot end before bit time 19, and stops there when enable is low;
- the request window always opens in bit time 2;
- the two line outputs are never low together.

Other behaviour can only be shown by the bench, comparing every cycle against its reference model:
- the sync pattern for each sync type;
- the MSB-first data coding and the parity value for chosen words;
- back-to-back framing when the sync type changes between words;
- inhibit applied part-way through a word;
- an abort followed by a fresh word.

// File: rtl/manch_word_pkg.sv
package manch_word_pkg;
  typedef enum logic [1:0] {
    LV_IDLE = 2'd0,
    LV_POS  = 2'd1,
    LV_NEG  = 2'd2
  } line_lvl_t;
endpackage

// File: rtl/manch_word_seq.sv
module manch_word_seq #(
  parameter int DATA_W    = 16,
  parameter int SYNC_BITS = 3,
  localparam int WORD_BITS = SYNC_BITS + DATA_W + 1,
  localparam int CW        = $clog2(WORD_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mrst,
  input  logic          en,
  input  logic          sync_sel,
  output logic          half,
  output logic          active,
  output logic [CW-1:0] bitcnt,
  output logic          cmd
);
  localparam logic [CW-1:0] LAST = CW'(WORD_BITS - 1);

  logic          half_d, active_d, cmd_d;
  logic [CW-1:0] bitcnt_d;
  logic          last_bit;

  assign last_bit = (bitcnt == LAST);

  always_comb begin
    half_d   = ~half;
    active_d = active;
    bitcnt_d = bitcnt;
    cmd_d    = cmd;
    if (mrst) begin
      half_d   = 1'b0;
      active_d = 1'b0;
      bitcnt_d = '0;
    end else if (half) begin
      if (!active) begin
        if (en) begin
          active_d = 1'b1;
          bitcnt_d = '0;
          cmd_d    = sync_sel;
        end
      end else if (last_bit) begin
        bitcnt_d = '0;
        if (en) cmd_d = sync_sel;
        else    active_d = 1'b0;
      end else begin
        bitcnt_d = bitcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half   <= 1'b0;
      active <= 1'b0;
      bitcnt <= '0;
      cmd    <= 1'b0;
    end else begin
      half   <= half_d;
      active <= active_d;
      bitcnt <= bitcnt_d;
      cmd    <= cmd_d;
    end
  end

  // R2
  phase_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mrst |=> half != $past(half));
  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrst |=> (!active && !half));
  // R7
  stop_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && last_bit && half && !en && !mrst) |=> !active);
  // R2
  no_early_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !(last_bit && half) && !mrst) |=> active);
endmodule

// File: rtl/manch_word_dpath.sv
module manch_word_dpath #(
  parameter int DATA_W    = 16,
  parameter int SYNC_BITS = 3,
  localparam int WORD_BITS = SYNC_BITS + DATA_W + 1,
  localparam int CW        = $clog2(WORD_BITS),
  localparam int REQ_FIRST = SYNC_BITS - 1,
  localparam int REQ_LAST  = SYNC_BITS + DATA_W - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mrst,
  input  logic          half,
  input  logic          active,
  input  logic [CW-1:0] bitcnt,
  input  logic          sdi,
  output logic          req,
  output logic          tx_bit,
  output logic          par_bit
);
  logic tx_bit_d, par_bit_d, take;

  assign req  = active && (int'(bitcnt) >= REQ_FIRST) && (int'(bitcnt) <= REQ_LAST);
  assign take = req && half && !mrst;

  always_comb begin
    tx_bit_d  = tx_bit;
    par_bit_d = par_bit;
    if (take) begin
      tx_bit_d  = sdi;
      par_bit_d = (int'(bitcnt) == REQ_FIRST) ? ~sdi : (par_bit ^ sdi);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_bit  <= 1'b0;
      par_bit <= 1'b1;
    end else begin
      tx_bit  <= tx_bit_d;
      par_bit <= par_bit_d;
    end
  end

  // R4
  req_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> (int'(bitcnt) == REQ_FIRST));
endmodule

// File: rtl/manch_word_mod.sv
module manch_word_mod
  import manch_word_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SYNC_BITS = 3,
  localparam int WORD_BITS = SYNC_BITS + DATA_W + 1,
  localparam int CW        = $clog2(WORD_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          half,
  input  logic          active,
  input  logic [CW-1:0] bitcnt,
  input  logic          cmd,
  input  logic          tx_bit,
  input  logic          par_bit,
  input  logic          inh_n,
  output logic          one_n,
  output logic          zero_n
);
  line_lvl_t lvl;
  logic      pos;
  int        half_idx;

  always_comb begin
    half_idx = int'(bitcnt) * 2 + int'(half);
    if (int'(bitcnt) < SYNC_BITS)
      pos = (half_idx < SYNC_BITS) ? cmd : ~cmd;
    else if (int'(bitcnt) < SYNC_BITS + DATA_W)
      pos = tx_bit ^ half;
    else
      pos = par_bit ^ half;
    if (!active || !inh_n) lvl = LV_IDLE;
    else if (pos)          lvl = LV_POS;
    else                   lvl = LV_NEG;
  end

  assign one_n  = (lvl != LV_POS);
  assign zero_n = (lvl != LV_NEG);

  // R10
  never_both_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (one_n || zero_n));
endmodule

// File: rtl/manch_word_tx.sv
module manch_word_tx #(
  parameter int DATA_W    = 16,
  parameter int SYNC_BITS = 3,
  localparam int WORD_BITS = SYNC_BITS + DATA_W + 1,
  localparam int CW        = $clog2(WORD_BITS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mrst,
  input  logic en,
  input  logic sync_sel,
  input  logic sdi,
  input  logic inh_n,
  output logic shclk,
  output logic req,
  output logic one_n,
  output logic zero_n
);
  logic          half, active, cmd, tx_bit, par_bit;
  logic [CW-1:0] bitcnt;

  manch_word_seq #(.DATA_W(DATA_W), .SYNC_BITS(SYNC_BITS)) seq_i (
    .clk(clk), .rst_n(rst_n), .mrst(mrst), .en(en), .sync_sel(sync_sel),
    .half(half), .active(active), .bitcnt(bitcnt), .cmd(cmd)
  );

  manch_word_dpath #(.DATA_W(DATA_W), .SYNC_BITS(SYNC_BITS)) dpath_i (
    .clk(clk), .rst_n(rst_n), .mrst(mrst), .half(half), .active(active),
    .bitcnt(bitcnt), .sdi(sdi), .req(req), .tx_bit(tx_bit), .par_bit(par_bit)
  );

  manch_word_mod #(.DATA_W(DATA_W), .SYNC_BITS(SYNC_BITS)) mod_i (
    .clk(clk), .rst_n(rst_n), .half(half), .active(active), .bitcnt(bitcnt),
    .cmd(cmd), .tx_bit(tx_bit), .par_bit(par_bit), .inh_n(inh_n),
    .one_n(one_n), .zero_n(zero_n)
  );

  assign shclk = ~half;
endmodule

// File: tb/manch_word_tx_tb_top.sv
module manch_word_tx_tb_top;
  logic clk = 1'b0;
  logic rst_n, mrst, en, sync_sel, sdi, inh_n;
  logic shclk, req, one_n, zero_n;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  manch_word_tx dut_i (
    .clk(clk), .rst_n(rst_n), .mrst(mrst), .en(en), .sync_sel(sync_sel),
    .sdi(sdi), .inh_n(inh_n), .shclk(shclk), .req(req),
    .one_n(one_n), .zero_n(zero_n)
  );

  // reference model state
  int m_h, m_act, m_bit, m_cmd, post_abort;
  logic [15:0] m_word, next_word;

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: got %b expected %b", tag, cycles, got, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_h = 0; m_act = 0; m_bit = 0; m_cmd = 0; post_abort = 0;
    end else if (mrst) begin
      m_h = 0; m_act = 0; m_bit = 0; post_abort = 1;
    end else begin
      post_abort = 0;
      if (m_h == 1) begin
        if (m_act == 0) begin
          if (en) begin m_act = 1; m_bit = 0; m_cmd = sync_sel; m_word = next_word; end
        end else if (m_bit == 19) begin
          if (en) begin m_bit = 0; m_cmd = sync_sel; m_word = next_word; end
          else begin m_act = 0; m_bit = 0; end
        end else m_bit++;
      end
      m_h = 1 - m_h;
    end
  end

  // source: one word bit per requested bit time, junk elsewhere
  always @(negedge clk) begin
    #1;
    if (m_act == 1 && m_bit >= 2 && m_bit <= 17) sdi = m_word[17 - m_bit];
    else sdi = m_h[0];
  end

  // per-cycle comparison
  always @(negedge clk) begin
    int lvl;
    logic v;
    string tag;
    cycles++;
    if (rst_n === 1'b1 && !done) begin
      lvl = 0;
      if (m_act == 1) begin
        if (m_bit < 3) begin
          v = (m_cmd == 1) ? (m_bit * 2 + m_h < 3) : (m_bit * 2 + m_h >= 3);
        end else if (m_bit < 19) begin
          v = (m_word[18 - m_bit] == 1'b1) == (m_h == 0);
        end else begin
          v = (~^m_word) == (m_h == 0);
        end
        lvl = v ? 1 : 2;
      end
      if (!inh_n) lvl = 0;
      if (post_abort == 1)  tag = "R9";
      else if (!inh_n)      tag = "R8";
      else if (m_act == 0)  tag = "R10";
      else if (m_bit < 3)   tag = "R3";
      else if (m_bit < 19)  tag = "R5";
      else                  tag = "R6";
      chk(tag, one_n, !(lvl == 1));
      chk(tag, zero_n, !(lvl == 2));
      chk("R4", req, (m_act == 1 && m_bit >= 2 && m_bit <= 17));
      chk("R2", shclk, (m_h == 0));
    end
  end

  task automatic step();
    @(negedge clk); #2;
  endtask

  task automatic wait_act(input int want);
    while (m_act != want) step();
  endtask

  task automatic wait_bit(input int b);
    while (!(m_act == 1 && m_bit == b)) step();
  endtask

  initial begin
    rst_n = 0; mrst = 0; en = 0; sync_sel = 0; inh_n = 1; next_word = 16'h0;
    repeat (3) step();
    // R1 reset state
    chk("R1", one_n, 1'b1); chk("R1", zero_n, 1'b1);
    chk("R1", req, 1'b0);   chk("R1", shclk, 1'b1);
    rst_n = 1;
    step();
    // single command word
    next_word = 16'hA5C3; sync_sel = 1; en = 1;
    wait_act(1); en = 0; sync_sel = 0;
    wait_act(0); repeat (6) step();
    // R7 back-to-back: data word then command word
    next_word = 16'h0000; sync_sel = 0; en = 1;
    wait_act(1);
    wait_bit(19); next_word = 16'hFFFF; sync_sel = 1;
    wait_bit(0);
    chk("R7 restart no gap", req, 1'b0);
    chk("R7 command sync first half", one_n, 1'b0);
    en = 0;
    wait_act(0);
    chk("R7 idle after word", one_n & zero_n, 1'b1);
    repeat (4) step();
    // R8 inhibit part-way
    next_word = 16'h1234; sync_sel = 0; en = 1;
    wait_act(1); en = 0;
    wait_bit(5); inh_n = 0;
    wait_bit(9); inh_n = 1;
    wait_act(0); repeat (4) step();
    // R9 abort then a fresh word
    next_word = 16'h8001; sync_sel = 1; en = 1;
    wait_bit(7); en = 0; mrst = 1;
    step(); mrst = 0;
    chk("R9 idle after abort", one_n & zero_n, 1'b1);
    repeat (9) step();
    next_word = 16'h7FFE; sync_sel = 0; en = 1;
    wait_act(1); en = 0;
    wait_act(0); repeat (4) step();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule